// File: doc/BRIEF.md
# I2C Address Phase Transmitter

This block sends the first byte of a controller-side I2C transaction: a 7-bit target address followed by the direction bit. A single-cycle request captures the address and the direction flag. The block then places one bit on the open-drain data line during each clock-low period, checks each released bit for a contending device, and samples the acknowledge slot.

Timing comes entirely from two single-cycle strobes supplied by the surrounding controller. One strobe marks the clock rising edge. The other marks a point shortly after the clock falling edge, when the data line may safely change. The block drives only a pull-low enable for the data line. Clock generation, START/STOP framing, data bytes and input synchronisation belong to the surrounding controller.

Top module: `addr_phase_tx`

## Requirements
- R1: A one-cycle `startReq` while idle captures `addrIn` and `readNotWrite`. The data line stays released until the first `sclFallDlyStb` after the request, and rising strobes before that strobe have no effect.
- R2: The eight transmitted bits are the address from its most significant bit to bit 0, then the direction bit, where 1 means read and 0 means write.
- R3: `sdaPullLow` is 1 only while a 0 bit is being sent. It is 0 for a 1 bit, during the acknowledge slot and while idle.
- R4: `sdaPullLow` changes only on a cycle following `sclFallDlyStb`, so it stays stable across every `sclRiseStb`.
- R5: On each `sclRiseStb` during the eight bits, `bitMismatch` becomes 1 if the line is released and `sdaIn` reads 0, and becomes 0 otherwise. A new start clears it.
- R6: After the eighth bit the line is released. On the ninth `sclRiseStb`, `noAck` takes the value of `sdaIn` (1 = not acknowledged) and holds it until the next start.
- R7: `done` is 0 from the start request until the `sclFallDlyStb` that follows the acknowledge rising strobe. It then becomes 1 and stays 1 until the next start.
- R8: A start request after `done` begins a fresh transfer with the new address and direction.
- R9: Synchronous active-low reset releases the line and clears `done`, `noAck` and `bitMismatch`. A transfer that is in progress when reset is applied is abandoned.
- R10: A `startReq` that arrives while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| startReq | input | 1 | One-cycle transfer request |
| addrIn | input | ADDR_W | Target address, captured on start |
| readNotWrite | input | 1 | Direction bit, captured on start (1 = read) |
| sdaIn | input | 1 | Synchronised data line level |
| sclRiseStb | input | 1 | One-cycle strobe at the clock rising edge |
| sclFallDlyStb | input | 1 | One-cycle strobe after the clock falling edge |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls the data line low |
| bitMismatch | output | 1 | A released bit was read back low |
| noAck | output | 1 | The acknowledge slot was read high |
| done | output | 1 | Address phase complete |

## Verification
The hardest situation to reach from the ports is a contending device pulling the line low while the block has released it. A second case is the same contention on one bit, followed by a clean bit, so that the flag must clear again. The bench models the bus as a wired-AND of the block's enable and a per-bit injection mask, and it chooses that mask at random for every transfer. A fixed pattern is also driven on an all-ones address. A start request in the middle of a transfer and a reset in the middle of a transfer are driven as directed cases at chosen bit positions.

// File: rtl/addr_tx_pkg.sv
package addr_tx_pkg;

  typedef struct packed {
    logic load;
    logic drive;
    logic relLine;
    logic sampleBit;
    logic sampleAck;
    logic finish;
  } txStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_BITS,
    ST_ACK_LOW,
    ST_ACK_HIGH
  } txState_e;

endpackage

// File: rtl/addr_tx_ctrl.sv
module addr_tx_ctrl
  import addr_tx_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       sclRiseStb,
  input  logic       sclFallDlyStb,
  output txStrobes_t strb
);

  localparam int CNT_W = $clog2(NBITS + 1);

  txState_e state, nextState;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.load = 1'b1;
          nextState = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (sclFallDlyStb) begin
          strb.drive = 1'b1;
          nextState  = ST_BITS;
        end
      end
      ST_BITS: begin
        strb.sampleBit = sclRiseStb;
        if (sclFallDlyStb) begin
          if (bitCnt == CNT_W'(NBITS)) begin
            strb.relLine = 1'b1;
            nextState    = ST_ACK_LOW;
          end else begin
            strb.drive = 1'b1;
          end
        end
      end
      ST_ACK_LOW: begin
        if (sclRiseStb) begin
          strb.sampleAck = 1'b1;
          nextState      = ST_ACK_HIGH;
        end
      end
      ST_ACK_HIGH: begin
        if (sclFallDlyStb) begin
          strb.finish = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state <= nextState;
      if (strb.load)       bitCnt <= '0;
      else if (strb.drive) bitCnt <= bitCnt + 1'b1;
    end
  end

  // R10: a request outside idle never reloads the transfer
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strb.load);

  p_one_action_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.drive, strb.relLine, strb.finish}));

  // R2: never more bits than address plus direction
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(NBITS));

endmodule

// File: rtl/addr_tx_dpath.sv
module addr_tx_dpath
  import addr_tx_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobes_t       strb,
  input  logic [NBITS-1:0] loadWord,
  input  logic             sdaIn,
  output logic             sdaPullLow,
  output logic             bitMismatch,
  output logic             noAck,
  output logic             done
);

  logic [NBITS-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg       <= '0;
      sdaPullLow  <= 1'b0;
      bitMismatch <= 1'b0;
      noAck       <= 1'b0;
      done        <= 1'b0;
    end else begin
      if (strb.load) begin
        shReg       <= loadWord;
        bitMismatch <= 1'b0;
        noAck       <= 1'b0;
        done        <= 1'b0;
      end
      if (strb.drive) begin
        sdaPullLow <= ~shReg[NBITS-1];
        shReg      <= {shReg[NBITS-2:0], 1'b0};
      end
      if (strb.relLine)   sdaPullLow  <= 1'b0;
      if (strb.sampleBit) bitMismatch <= ~sdaPullLow & ~sdaIn;
      if (strb.sampleAck) noAck       <= sdaIn;
      if (strb.finish)    done        <= 1'b1;
    end
  end

  // R3: the line is never held low once the phase is complete
  p_done_released_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !sdaPullLow);

  // R1: a load leaves every output cleared and the line released
  p_load_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (!done && !noAck && !bitMismatch && !sdaPullLow));

endmodule

// File: rtl/addr_phase_tx.sv
module addr_phase_tx
  import addr_tx_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              readNotWrite,
  input  logic              sdaIn,
  input  logic              sclRiseStb,
  input  logic              sclFallDlyStb,
  output logic              sdaPullLow,
  output logic              bitMismatch,
  output logic              noAck,
  output logic              done
);

  localparam int NBITS = ADDR_W + 1;

  txStrobes_t strb;

  addr_tx_ctrl #(.NBITS(NBITS)) i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .startReq      (startReq),
    .sclRiseStb    (sclRiseStb),
    .sclFallDlyStb (sclFallDlyStb),
    .strb          (strb)
  );

  addr_tx_dpath #(.NBITS(NBITS)) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .loadWord    ({addrIn, readNotWrite}),
    .sdaIn       (sdaIn),
    .sdaPullLow  (sdaPullLow),
    .bitMismatch (bitMismatch),
    .noAck       (noAck),
    .done        (done)
  );

  // R4: the line only moves after a delayed falling strobe
  p_hold_between_falls_r4: assert property (@(posedge clk) disable iff (!rstN)
    !sclFallDlyStb |=> $stable(sdaPullLow));

  // R7: completion is signalled only after a falling strobe
  p_done_after_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(sclFallDlyStb));

  // R6: no-acknowledge only appears from a rising-strobe sample of a high line
  p_noack_from_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(noAck) |-> $past(sclRiseStb && sdaIn));

  // R5: mismatch needs a released line read low on a rising strobe
  p_mismatch_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitMismatch) |-> $past(sclRiseStb && !sdaPullLow && !sdaIn));

endmodule

// File: tb/test_addr_phase_tx.sv
module test_addr_phase_tx;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [6:0] addrIn = '0;
  logic       readNotWrite = 1'b0;
  logic       sclRiseStb = 1'b0;
  logic       sclFallDlyStb = 1'b0;
  logic       extLow = 1'b0;
  logic       sdaIn;
  logic       sdaPullLow, bitMismatch, noAck, done;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // wired-AND bus: either side can pull low
  assign sdaIn = !(sdaPullLow || extLow);

  always #(CLK_PERIOD / 2) clk = ~clk;

  addr_phase_tx #(.ADDR_W(7)) i_addr_phase_tx (
    .clk           (clk),
    .rstN          (rstN),
    .startReq      (startReq),
    .addrIn        (addrIn),
    .readNotWrite  (readNotWrite),
    .sdaIn         (sdaIn),
    .sclRiseStb    (sclRiseStb),
    .sclFallDlyStb (sclFallDlyStb),
    .sdaPullLow    (sdaPullLow),
    .bitMismatch   (bitMismatch),
    .noAck         (noAck),
    .done          (done)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expPull(input logic [7:0] word, input int idx);
    return !word[7 - idx];
  endfunction

  task automatic pulseFall();
    @(negedge clk) sclFallDlyStb = 1'b1;
    @(negedge clk) sclFallDlyStb = 1'b0;
  endtask

  task automatic pulseRise();
    @(negedge clk) sclRiseStb = 1'b1;
    @(negedge clk) sclRiseStb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runXfer(input logic [6:0] a, input logic rw, input logic [7:0] inj,
                         input logic ack, input bit midStart, input bit randGap);
    logic [7:0] word;
    logic bitv;
    word = {a, rw};
    @(negedge clk);
    startReq = 1'b1; addrIn = a; readNotWrite = rw;
    @(negedge clk);
    startReq = 1'b0; addrIn = ~a; readNotWrite = ~rw;
    chk("R1 released after start", sdaPullLow, 1'b0);
    chk("R5 mismatch cleared by start", bitMismatch, 1'b0);
    chk("R6 noAck cleared by start", noAck, 1'b0);
    chk("R7 done low after start", done, 1'b0);
    pulseRise();
    chk("R1 rising strobe before first fall ignored", sdaPullLow, 1'b0);
    for (int i = 0; i < 8; i++) begin
      bitv = word[7 - i];
      pulseFall();
      chk("R2 R3 bit value on line", sdaPullLow, expPull(word, i));
      if (randGap) idle($urandom_range(0, 3));
      if (midStart && i == 3) begin
        @(negedge clk);
        startReq = 1'b1; addrIn = ~a; readNotWrite = ~rw;
        @(negedge clk);
        startReq = 1'b0;
        chk("R10 start mid-transfer ignored", done, 1'b0);
      end
      extLow = inj[7 - i];
      pulseRise();
      chk("R5 mismatch sample", bitMismatch, bitv & inj[7 - i]);
      chk("R4 stable across rising strobe", sdaPullLow, expPull(word, i));
      chk("R7 done low during bits", done, 1'b0);
      extLow = 1'b0;
    end
    pulseFall();
    chk("R6 released for ack slot", sdaPullLow, 1'b0);
    chk("R7 done low in ack slot", done, 1'b0);
    extLow = ack;
    pulseRise();
    chk("R6 noAck sample", noAck, !ack);
    chk("R7 done low before final fall", done, 1'b0);
    pulseFall();
    extLow = 1'b0;
    chk("R7 done after final fall", done, 1'b1);
    idle(3);
    chk("R7 done holds", done, 1'b1);
    chk("R6 noAck holds", noAck, !ack);
    chk("R3 released while idle", sdaPullLow, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      fails++;
      $display("FAIL R7 watchdog: actual %0d cycles expected below %0d", cycles, MAX_CYCLES);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    chk("R9 reset pull", sdaPullLow, 1'b0);
    chk("R9 reset done", done, 1'b0);
    chk("R9 reset noAck", noAck, 1'b0);
    chk("R9 reset mismatch", bitMismatch, 1'b0);
    @(negedge clk) rstN = 1'b1;
    idle(2);

    runXfer(7'b1110101, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0);
    runXfer(7'b0001010, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);   // R8 back-to-back
    runXfer(7'b0001010, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);   // R6 no ack
    runXfer(7'b1111111, 1'b0, 8'b10101010, 1'b1, 1'b0, 1'b0); // R5 pattern
    runXfer(7'b0110011, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);   // R10

    // R9 reset in the middle of a transfer
    @(negedge clk);
    startReq = 1'b1; addrIn = 7'b0000000; readNotWrite = 1'b0;
    @(negedge clk) startReq = 1'b0;
    pulseFall();
    chk("R9 pre-reset bit driven", sdaPullLow, 1'b1);
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    chk("R9 mid-transfer reset releases line", sdaPullLow, 1'b0);
    chk("R9 mid-transfer reset clears done", done, 1'b0);
    @(negedge clk) rstN = 1'b1;
    pulseFall();
    chk("R9 no drive after reset", sdaPullLow, 1'b0);
    runXfer(7'b1010101, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0);

    for (int k = 0; k < 24; k++) begin
      runXfer(7'($urandom), 1'($urandom), 8'($urandom), 1'($urandom),
              1'($urandom_range(0, 3) == 0), 1'b1);   // R8 random back-to-back
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule